// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog peripheral on a 32-bit word register bus. A programmable divider turns the core clock into a slow tick, normally one millisecond. A 16-bit tick counter advances on each tick while three enable bits in the control word are all set. When the counter equals the programmed timeout and reset generation is enabled, the block drives a system reset request for a fixed number of clock cycles.

Software restarts the count by writing any value to a dedicated kick location. To change the timeout, software kicks first and then writes the new limit. The live count can be read back in the upper half of the timeout word. Clearing the run bit pauses the watchdog. Setting it again resumes counting from where it stopped, with no other field rewritten.

Top module: `wdt_core`

## Requirements
- R1: After synchronous reset, every register reads zero and `rst_req_o` is low, so the watchdog starts disabled.
- R2: The control word is at byte offset 0x0. Bits 17:0 hold the divider value N, bit 18 is run, bit 21 is reset-enable, bit 24 is count-clock enable and bit 25 is divider enable. All other bits read as zero and ignore writes.
- R3: The timeout word is at byte offset 0x8. Bits 15:0 hold the timeout T and can be read and written. Bits 31:16 read the live count and ignore writes.
- R4: Any write to byte offset 0xC restarts the count at zero and clears the divider phase. A read of 0xC returns zero.
- R5: The count advances by one every max(N,1) clock cycles, and only while run, count-clock enable and divider enable are all set.
- R6: The control write that starts counting from a cleared state is cycle 0. The count reaches T after T·max(N,1) cycles. `rst_req_o` rises one cycle later and stays high for exactly 16 cycles.
- R7: While reset-enable is clear, no reset request is produced, and the count stops at T.
- R8: After expiry the count holds at T, with no second request, until a kick or until run is cleared.
- R9: Clearing run freezes the count. Setting run again resumes counting from the frozen value.
- R10: Offsets other than 0x0, 0x8 and 0xC ignore writes and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address, zero when not reading |
| rst_req_o | output | 1 | System reset request pulse |

## Verification
Register writes take effect at the clock edge that accepts them. Read data is combinational, so the bench samples it at the falling edge that follows the address being set. The count needs T·max(N,1) edges after the enabling write to reach T, and the request register adds one more edge. The bench therefore counts falling edges from the write until the first high sample and expects exactly T·max(N,1)+1. It then counts high samples and expects 16. For pause and resume, the divider phase at the moment of the pause is not visible at the ports, so the bench checks the remaining time against a window one tick wide.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    parameter int DATA_W    = 32;
    parameter int ADDR_W    = 4;
    parameter int DIV_W     = 18;
    parameter int CNT_W     = 16;
    parameter int PULSE_LEN = 16;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_TERM = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_KICK = 4'hC;

    localparam int BIT_RUN    = 18;
    localparam int BIT_RSTEN  = 21;
    localparam int BIT_CLKEN  = 24;
    localparam int BIT_DIVEN  = 25;

    typedef struct packed {
        logic             div_en;
        logic             clk_en;
        logic             rst_en;
        logic             run;
        logic [DIV_W-1:0] div;
    } ctrl_t;

    function automatic ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.div    = w[DIV_W-1:0];
        c.run    = w[BIT_RUN];
        c.rst_en = w[BIT_RSTEN];
        c.clk_en = w[BIT_CLKEN];
        c.div_en = w[BIT_DIVEN];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[DIV_W-1:0] = c.div;
        w[BIT_RUN]   = c.run;
        w[BIT_RSTEN] = c.rst_en;
        w[BIT_CLKEN] = c.clk_en;
        w[BIT_DIVEN] = c.div_en;
        return w;
    endfunction

    function automatic logic counting(input ctrl_t c);
        return c.run & c.clk_en & c.div_en;
    endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  live_cnt,
    output ctrl_t             ctrl_q,
    output logic [CNT_W-1:0]  limit_q,
    output logic              kick,
    output logic [DATA_W-1:0] bus_rdata
);
    logic wr_en, rd_en;
    assign wr_en = bus_sel & bus_wr;
    assign rd_en = bus_sel & ~bus_wr;
    assign kick  = wr_en && (bus_addr == OFS_KICK);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            limit_q <= '0;
        end else if (wr_en) begin
            if (bus_addr == OFS_CTRL) ctrl_q  <= word_to_ctrl(bus_wdata);
            if (bus_addr == OFS_TERM) limit_q <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (bus_addr)
                OFS_CTRL: bus_rdata = ctrl_to_word(ctrl_q);
                OFS_TERM: bus_rdata = {live_cnt, limit_q};
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clear,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] last;

    assign last = (div == '0) ? '0 : div - 1'b1;
    assign tick = run && (phase_q >= last);

    always_ff @(posedge clk) begin
        if (rst || clear)
            phase_q <= '0;
        else if (run)
            phase_q <= tick ? '0 : phase_q + 1'b1;
    end
endmodule

// File: rtl/wdt_tickcnt.sv
module wdt_tickcnt
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             kick,
    input  logic             wd_on,
    input  logic             rst_en,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt_q,
    output logic             fire
);
    logic at_limit;
    logic fired_q;

    assign at_limit = (cnt_q == limit);
    assign fire     = run && rst_en && at_limit && !fired_q && !kick;

    always_ff @(posedge clk) begin
        if (rst || kick)
            cnt_q <= '0;
        else if (tick && !at_limit)
            cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || kick || !wd_on)
            fired_q <= 1'b0;
        else if (fire)
            fired_q <= 1'b1;
    end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse
    import wdt_pkg::*;
#(
    parameter int LEN = PULSE_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic req
);
    localparam int LW = $clog2(LEN + 1);
    logic [LW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (fire)
            left_q <= LW'(LEN);
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign req = (left_q != '0);
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req_o
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] live_cnt;
    logic             kick, run, tick, fire;

    assign run = counting(ctrl_q);

    wdt_regs u_regs (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .live_cnt(live_cnt),
        .ctrl_q(ctrl_q), .limit_q(limit_q), .kick(kick), .bus_rdata(bus_rdata)
    );

    wdt_prescaler u_pre (
        .clk(clk), .rst(rst), .run(run), .clear(kick),
        .div(ctrl_q.div), .tick(tick)
    );

    wdt_tickcnt u_cnt (
        .clk(clk), .rst(rst), .run(run), .tick(tick), .kick(kick),
        .wd_on(ctrl_q.run), .rst_en(ctrl_q.rst_en), .limit(limit_q),
        .cnt_q(live_cnt), .fire(fire)
    );

    wdt_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst(rst), .fire(fire), .req(rst_req_o)
    );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
    import wdt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             kick_wr,
    input logic             run,
    input logic             rst_en,
    input logic [CNT_W-1:0] live_cnt,
    input logic             rst_req_o
);
    localparam int HW = $clog2(PULSE_LEN + 2);
    logic [HW-1:0] high_len;

    always_ff @(posedge clk) begin
        if (rst)            high_len <= '0;
        else if (rst_req_o) high_len <= high_len + 1'b1;
        else                high_len <= '0;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !rst_req_o);

    // R4
    kick_zero_chk: assert property (@(posedge clk) disable iff (rst)
        kick_wr |=> live_cnt == '0);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !kick_wr) |=> $stable(live_cnt));

    // R5
    unit_step_chk: assert property (@(posedge clk) disable iff (rst)
        !kick_wr |=> (live_cnt == $past(live_cnt) ||
                      live_cnt == CNT_W'($past(live_cnt) + 1'b1)));

    // R6
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst_req_o) && !$past(rst)) |-> high_len == HW'(PULSE_LEN));

    // R7
    no_req_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst_en && !rst_req_o) |=> !rst_req_o);
endmodule

bind wdt_core wdt_chk u_chk (
    .clk(clk), .rst(rst), .kick_wr(kick), .run(run),
    .rst_en(ctrl_q.rst_en), .live_cnt(live_cnt), .rst_req_o(rst_req_o)
);

// File: tb/wdt_core_tb.sv
module wdt_core_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req_o;

    int n_chk = 0, n_fail = 0;

    localparam logic [31:0] EN_ALL = (32'd1 << 18) | (32'd1 << 21) | (32'd1 << 24) | (32'd1 << 25);
    localparam logic [31:0] NO_RST = (32'd1 << 18) | (32'd1 << 24) | (32'd1 << 25);

    typedef struct packed { logic [17:0] div; logic [15:0] lim; logic [31:0] due; } vec_t;
    localparam vec_t VECS [6] = '{
        '{18'd4,  16'd5,  32'd21},
        '{18'd0,  16'd3,  32'd4},
        '{18'd1,  16'd7,  32'd8},
        '{18'd3,  16'd0,  32'd1},
        '{18'd10, 16'd6,  32'd61},
        '{18'd2,  16'd20, 32'd41}
    };

    always #5 clk = ~clk;

    wdt_core u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rst_req_o(rst_req_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_req(input int limit, output int k);
        k = 0;
        while (!rst_req_o && k < limit) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: run hung, got 0x0 expected 0x1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int k, w, c1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, d); check(d == 0, "R1 ctrl", d, 0);
        rd(4'h8, d); check(d == 0, "R1 term", d, 0);
        check(rst_req_o == 1'b0, "R1 req", {31'd0, rst_req_o}, 0);

        // R2 field layout, unused bits
        wr(4'h8, 32'h0000_FFFF);
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, d); check(d == 32'h0327_FFFF, "R2 mask", d, 32'h0327_FFFF);
        wr(4'h0, 32'h0);

        // R3 term readback, upper half read-only
        wr(4'hC, 32'h0);
        wr(4'h8, 32'hABCD_1234);
        rd(4'h8, d); check(d == 32'h0000_1234, "R3 term", d, 32'h0000_1234);

        // R10 unused offset
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, d); check(d == 0, "R10 hole", d, 0);
        rd(4'h0, d); check(d == 0, "R10 ctrl untouched", d, 0);

        // R4 kick reads zero
        rd(4'hC, d); check(d == 0, "R4 kick read", d, 0);

        // R6 R8 vector table walk
        foreach (VECS[i]) begin
            wr(4'h0, 32'h0);
            wr(4'hC, 32'h1234_5678);
            wr(4'h8, {16'h0, VECS[i].lim});
            wr(4'h0, EN_ALL | {14'h0, VECS[i].div});
            wait_req(2000, k);
            check(k == VECS[i].due, "R6 due", k, VECS[i].due);
            w = 0;
            while (rst_req_o && w < 100) begin @(negedge clk); w++; end
            check(w == 16, "R6 width", w, 16);
            rd(4'h8, d); check(d[31:16] == VECS[i].lim, "R8 hold", d[31:16], VECS[i].lim);
            wait_req(40, k);
            check(k == 40, "R8 single", k, 40);
        end

        // R5 missing clock enable: no counting
        wr(4'h0, 32'h0); wr(4'hC, 0); wr(4'h8, 32'd100);
        wr(4'h0, ((32'd1 << 18) | (32'd1 << 21) | (32'd1 << 25)) | 32'd1);
        repeat (50) @(negedge clk);
        rd(4'h8, d); check(d[31:16] == 0, "R5 gated", d[31:16], 0);

        // R4 kick mid-count
        wr(4'h0, EN_ALL | 32'd2);
        repeat (30) @(negedge clk);
        rd(4'h8, d); check(d[31:16] != 0, "R4 running", d[31:16], 1);
        wr(4'hC, 32'hDEAD_BEEF);
        rd(4'h8, d); check(d[31:16] == 0, "R4 restart", d[31:16], 0);

        // R7 no reset request when reset-enable is clear
        wr(4'h0, 32'h0); wr(4'hC, 0); wr(4'h8, 32'd3);
        wr(4'h0, NO_RST | 32'd2);
        wait_req(40, k);
        check(k == 40, "R7 silent", k, 40);
        rd(4'h8, d); check(d[31:16] == 3, "R7 stop", d[31:16], 3);

        // R9 pause and resume
        wr(4'h0, 32'h0); wr(4'hC, 0); wr(4'h8, 32'd10);
        wr(4'h0, EN_ALL | 32'd4);
        repeat (14) @(negedge clk);
        wr(4'h0, EN_ALL & ~(32'd1 << 18) | 32'd4);
        rd(4'h8, d); c1 = d[31:16];
        repeat (30) @(negedge clk);
        rd(4'h8, d); check(d[31:16] == c1, "R9 frozen", d[31:16], c1);
        wr(4'h0, EN_ALL | 32'd4);
        wait_req(200, k);
        check(k <= (10 - c1) * 4 + 1 && k >= (10 - c1 - 1) * 4 + 1, "R9 resume", k, (10 - c1) * 4 + 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule